// File: doc/BRIEF.md
# Pixel FIFO Refill and Unpacker

This block sits between a memory-side word source and a display pixel pipeline. It keeps a small queue of 32-bit frame-buffer words. When the block is enabled, it asks a DMA-style fetch master for more words whenever there is room for a full burst. It takes those words in through a valid/ready stream.

On the pixel side, every pixel-clock enable takes one pixel code from the word at the head of the queue. Codes are taken starting at the least significant bits, with a depth of 1, 2, 4, 8 or 16 bits chosen at run time. The head word is freed in the same cycle that its last code is emitted, so the following word is used at the very next enable with no gap.

If a pixel is due while the queue is empty, the block raises a sticky underrun flag and repeats the previous code. Turning the block off empties the queue, withdraws the request and moves the extraction point back to bit 0 of a word.

The input stream follows these rules:
- A word transfers on a rising edge where `in_valid` and `in_ready` are both high.
- The source must hold `in_data` steady while `in_valid` is high and `in_ready` is low.
- `in_ready` never depends on `in_valid`.
- The pixel side applies no back-pressure: `pix_en` is a demand and must be served in every cycle it is high.

Top module: `pix_word_unpacker`

## Requirements
- R1: After reset, `pix_valid`, `fill_req` and `underrun` are 0. While `enable` is 0, `in_ready` and `fill_req` are 0.
- R2: `fill_req` is 1 exactly when `enable` is 1 and at least BURST (4) of the DEPTH (16) entries are free. It follows the occupancy in the cycle after each push or pop.
- R3: `in_ready` is 1 when `enable` is 1 and fewer than DEPTH words are held. A word is stored only on a cycle where `in_valid` and `in_ready` are both 1, so the queue never overflows.
- R4: `depth_sel` picks the code width: 0 gives 1 bit, 1 gives 2, 2 gives 4, 3 gives 8, and 4 or any larger value gives 16. Code k of a word is bits [k*W +: W], where W is the code width, zero-extended to 16 bits.
- R5: A word yields 32/W codes. The word is freed in the cycle its last code is emitted, and the next word's first code follows at the next `pix_en` with no gap.
- R6: `pix_valid` is 1 in the cycle after a rising edge where `pix_en` and `enable` were both 1, and 0 otherwise. `pix_code` updates on that same edge.
- R7: A `pix_en` while the queue is empty sets `underrun`. On that edge `pix_valid` is still 1, and `pix_code` repeats its previous value.
- R8: `underrun` stays at 1 until a cycle with `underrun_clr` high. If a new underrun happens in the same cycle as the clear, the new underrun wins.
- R9: Dropping `enable` empties the queue, withdraws `fill_req` and resets the extraction point to bit 0. A `pix_en` while disabled gives no `pix_valid`.
- R10: Words are unpacked in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block on; when low, the queue is flushed |
| depth_sel | input | 3 | Code width select (0:1, 1:2, 2:4, 3:8, 4+:16 bits) |
| in_valid | input | 1 | Word stream valid |
| in_ready | output | 1 | Word stream ready |
| in_data | input | 32 | Frame-buffer word |
| fill_req | output | 1 | Refill request toward the fetch master |
| pix_en | input | 1 | Pixel-clock enable (demand for one code) |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| pix_valid | output | 1 | Code strobe, one cycle after `pix_en` |
| pix_code | output | 16 | Zero-extended pixel code |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench streams two back-to-back words at every depth, including an out-of-range select, and checks each code against a shift-and-mask model. A design that inserted a bubble at a word boundary would show up there as a false underrun or a shifted code sequence. A design that took codes from the wrong end of the word would show up as codes in the wrong order.

It fills the queue across the burst threshold and to full. This catches a request threshold that is off by one and a ready signal that still accepts a word when the queue is full.

It turns the block off halfway through a word and then on again. A design that did not flush the queue, or did not reset the extraction point, would then emit stale bytes instead of byte 0 of the new word.

Finally, it checks that underrun repeats the last code, stays set, and wins over a clear in the same cycle.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  // log2 of the code width for a depth select; values past 16-bit clamp to 16
  function automatic logic [2:0] depth_lg(input logic [2:0] sel);
    case (sel)
      3'd0:    return 3'd0;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pfu_word_fifo.sv
module pfu_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] din,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && wr_ptr == AW'(g)) mem[g] <= din;
    end
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)) || pop);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
endmodule

// File: rtl/pfu_refill.sv
module pfu_refill #(
  parameter int DEPTH  = 16,
  parameter int BURST  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  output logic             fill_req,
  output logic             in_ready
);
  logic [CNT_W-1:0] free_slots;

  always_comb begin
    free_slots = CNT_W'(DEPTH) - count;
    fill_req   = enable && (free_slots >= CNT_W'(BURST));
    in_ready   = enable && (count != CNT_W'(DEPTH));
  end
endmodule

// File: rtl/pfu_unpack.sv
module pfu_unpack #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 16,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        depth_sel,
  input  logic [WORD_W-1:0] head,
  input  logic              head_ok,
  input  logic              pix_en,
  input  logic              underrun_clr,
  output logic              pop,
  output logic              pix_valid,
  output logic [CODE_W-1:0] pix_code,
  output logic              underrun
);
  logic [2:0]        lg;
  logic [POS_W-1:0]  pos, last_pos, sh;
  logic [POS_W:0]    width;
  logic [WORD_W-1:0] shifted, mask;
  logic              step, take;

  always_comb begin
    lg       = pfu_pkg::depth_lg(depth_sel);
    width    = (POS_W+1)'(1) << lg;
    last_pos = POS_W'((WORD_W >> lg) - 1);
    sh       = pos << lg;
    shifted  = head >> sh;
    mask     = ~({WORD_W{1'b1}} << width);
    step     = pix_en && enable;
    take     = step && head_ok;
    pop      = take && (pos >= last_pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      pix_valid <= 1'b0;
      pix_code  <= '0;
      underrun  <= 1'b0;
    end else begin
      pix_valid <= step;
      if (!enable)   pos <= '0;
      else if (pop)  pos <= '0;
      else if (take) pos <= pos + 1'b1;
      if (take) pix_code <= CODE_W'(shifted & mask);
      if (step && !head_ok) underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
    end
  end

  assert_pos_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pos == '0);
  assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && enable) |=> pix_valid);
  assert_hold_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && enable && !head_ok) |=> $stable(pix_code) && underrun);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);
endmodule

// File: rtl/pix_word_unpacker.sv
module pix_word_unpacker #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 16,
  parameter int DEPTH  = 16,
  parameter int BURST  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        depth_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              fill_req,
  input  logic              pix_en,
  input  logic              underrun_clr,
  output logic              pix_valid,
  output logic [CODE_W-1:0] pix_code,
  output logic              underrun
);
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] head;
  logic              push, pop, head_ok;

  assign push    = in_valid && in_ready;
  assign head_ok = count != '0;

  pfu_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!enable), .push(push), .din(in_data),
    .pop(pop), .head(head), .count(count));

  pfu_refill #(.DEPTH(DEPTH), .BURST(BURST)) u_refill (
    .enable(enable), .count(count), .fill_req(fill_req), .in_ready(in_ready));

  pfu_unpack #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
    .head(head), .head_ok(head_ok), .pix_en(pix_en),
    .underrun_clr(underrun_clr), .pop(pop), .pix_valid(pix_valid),
    .pix_code(pix_code), .underrun(underrun));

  assert_req_has_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> in_ready);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !in_ready && !fill_req);
endmodule

// File: tb/pix_word_unpacker_tb.sv
`timescale 1ns/1ps
module pix_word_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  depth_sel = 3'd4;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        fill_req;
  logic        pix_en = 1'b0;
  logic        underrun_clr = 1'b0;
  logic        pix_valid;
  logic [15:0] pix_code;
  logic        underrun;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  pix_word_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .fill_req(fill_req), .pix_en(pix_en), .underrun_clr(underrun_clr),
    .pix_valid(pix_valid), .pix_code(pix_code), .underrun(underrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1 chk("R3 ready before push", in_ready, 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic restart(input logic [2:0] sel);
    @(negedge clk);
    enable = 1'b0;
    underrun_clr = 1'b1;
    depth_sel = sel;
    @(negedge clk);
    underrun_clr = 1'b0;
    enable = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 pix_valid", pix_valid, 0);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 in_ready off", in_ready, 0);
  endtask

  task automatic t_fill;
    restart(3'd4);
    #1 chk("R2 empty request", fill_req, 1);
    for (int i = 0; i < 12; i++) push_word(32'h1000 + i);
    chk("R2 four free", fill_req, 1);
    push_word(32'h100C);
    chk("R2 three free", fill_req, 0);
    for (int i = 13; i < 16; i++) push_word(32'h1000 + i);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 32'hDEAD_BEEF;
    #1 chk("R3 full not ready", in_ready, 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    pix_en = 1'b1;
    @(posedge clk);
    #1 chk("R10 first word low", pix_code, 32'h1000);
    @(posedge clk);
    #1 chk("R10 first word high", pix_code, 0);
    @(negedge clk);
    pix_en = 1'b0;
    #1 chk("R3 ready after pop", in_ready, 1);
    chk("R2 one free", fill_req, 0);
    @(posedge clk);
    #1 chk("R6 no strobe", pix_valid, 0);
    @(negedge clk);
    pix_en = 1'b1;
    @(posedge clk);
    #1 chk("R10 second word", pix_code, 32'h1001);
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic t_depth(input logic [2:0] sel, input int lg,
                         input logic [31:0] w0, input logic [31:0] w1);
    int width = 1 << lg;
    int ppw = 32 >> lg;
    logic [31:0] mask = ~(32'hFFFF_FFFF << width);
    logic [31:0] exp = '0;
    restart(sel);
    push_word(w0);
    push_word(w1);
    @(negedge clk);
    pix_en = 1'b1;
    for (int i = 0; i < 2 * ppw; i++) begin
      logic [31:0] w = (i < ppw) ? w0 : w1;
      @(posedge clk);
      #1;
      exp = (w >> ((i % ppw) * width)) & mask;
      chk("R6 strobe", pix_valid, 1);
      chk("R4 code", pix_code, exp);
    end
    chk("R5 no bubble", underrun, 0);
    @(posedge clk);
    #1 chk("R7 underrun set", underrun, 1);
    chk("R7 code held", pix_code, exp);
    chk("R7 strobe kept", pix_valid, 1);
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic t_sticky;
    restart(3'd3);
    @(negedge clk);
    pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
    chk("R7 empty underrun", underrun, 1);
    repeat (3) @(posedge clk);
    #1 chk("R8 sticky", underrun, 1);
    @(negedge clk);
    underrun_clr = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0;
    chk("R8 cleared", underrun, 0);
    pix_en = 1'b1;
    underrun_clr = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
    underrun_clr = 1'b0;
    chk("R8 set wins", underrun, 1);
  endtask

  task automatic t_disable;
    restart(3'd3);
    push_word(32'h4433_2211);
    push_word(32'h8877_6655);
    @(negedge clk);
    pix_en = 1'b1;
    @(posedge clk);
    #1 chk("R4 byte0", pix_code, 32'h11);
    @(posedge clk);
    #1 chk("R4 byte1", pix_code, 32'h22);
    @(negedge clk);
    enable = 1'b0;
    @(posedge clk);
    #1 chk("R9 request off", fill_req, 0);
    chk("R9 ready off", in_ready, 0);
    @(posedge clk);
    #1 chk("R9 no strobe while off", pix_valid, 0);
    @(negedge clk);
    pix_en = 1'b0;
    enable = 1'b1;
    underrun_clr = 1'b1;
    #1 chk("R9 flushed request", fill_req, 1);
    @(negedge clk);
    underrun_clr = 1'b0;
    push_word(32'hDDCC_BBAA);
    @(negedge clk);
    pix_en = 1'b1;
    @(posedge clk);
    #1 chk("R9 pos reset", pix_code, 32'hAA);
    @(posedge clk);
    #1 chk("R9 next byte", pix_code, 32'hBB);
    chk("R9 no stale", underrun, 0);
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 disabled ready", in_ready, 0);
    t_fill();
    t_depth(3'd0, 0, 32'hA5C3_0F1E, 32'h8000_0001);
    t_depth(3'd1, 1, 32'h1B2D_E4F6, 32'hC003_9A5B);
    t_depth(3'd2, 2, 32'h7654_3210, 32'hFEDC_BA98);
    t_depth(3'd3, 3, 32'h4433_2211, 32'hCAFE_F00D);
    t_depth(3'd4, 4, 32'hABCD_1234, 32'h5678_9EF0);
    t_depth(3'd7, 4, 32'h0F0F_F0F0, 32'h1357_2468);
    t_sticky();
    t_disable();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule